// File: doc/BRIEF.md
# Byte Queue with Level and Overflow Interrupts

This block is a 32-deep byte queue that sits between a serial transmitter or receiver and the register file. One side pushes bytes and the other side pops them. The head byte is visible at the output whenever the queue holds data. The block reports the current number of stored bytes. It also gives software a flush that empties the queue at any fill level.

Two interrupt state bits are kept. The level bit is set when the stored count reaches a threshold picked from a small encoded set. The overflow bit is set when a byte arrives while the queue is full and nothing leaves in the same cycle. Both bits are sticky and are cleared by a write-one-to-clear input. Each interrupt line is its state bit gated by its enable bit.

Top module: `uart_wm_fifo`

## Requirements
- R1: Bytes are popped in the order they were pushed. When `pop_valid_o` is high, `pop_data_o` shows the oldest stored byte. Up to 32 bytes are held.
- R2: `level_o` equals the stored count, from 0 to 32, and is 0 after reset. `push_ready_o` is low exactly at 32 and `pop_valid_o` is low exactly at 0.
- R3: A push at level 32 with no pop and no flush in the same cycle is discarded and leaves the level at 32. On the next cycle it sets overflow state bit `irq_state_o[1]`.
- R4: A push and a pop in the same cycle at level 32 are both accepted. The level stays 32 and no overflow is flagged.
- R5: A pop at level 0 has no effect. The level stays 0 unless a push in the same cycle adds one byte.
- R6: `wm_sel_i` picks the threshold: 0 gives 1, 1 gives 4, 2 gives 8, 3 gives 16, and 4 to 7 give 30. Level state bit `irq_state_o[0]` is set one cycle after a cycle in which the level is at or above the threshold.
- R7: The level state bit stays set after the level falls below the threshold. `irq_clr_i[0]` clears it only in a cycle where the level is below the threshold. A clear issued while the level is at or above the threshold has no effect.
- R8: The overflow state bit stays set until `irq_clr_i[1]` is high. If a new overflow occurs in the same cycle as the clear, the bit stays set.
- R9: When `flush_i` is high, the level is 0 on the next cycle. Any push or pop in that cycle is ignored, and no byte stored before the flush ever appears at `pop_data_o`.
- R10: `irq_o[i]` is `irq_state_o[i]` ANDed with `irq_en_i[i]`, where bit 0 is the level interrupt and bit 1 is the overflow interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Empty the queue |
| push_i | input | 1 | Push request |
| push_data_i | input | 8 | Byte to push |
| push_ready_o | output | 1 | Queue is not full |
| pop_i | input | 1 | Pop request |
| pop_data_o | output | 8 | Oldest stored byte |
| pop_valid_o | output | 1 | Queue is not empty |
| level_o | output | 6 | Stored byte count |
| wm_sel_i | input | 3 | Threshold select code |
| irq_en_i | input | 2 | Interrupt enables (0 level, 1 overflow) |
| irq_clr_i | input | 2 | Write-one-to-clear for the state bits |
| irq_state_o | output | 2 | Interrupt state bits |
| irq_o | output | 2 | Enabled interrupt requests |

## Verification
The assertions check several rules on every cycle:
- the level bound and the agreement of the ready and valid flags with the level;
- that a flush always lands at zero;
- that a push-and-pop at full keeps the level;
- that an unmatched push at full sets the overflow bit;
- that neither state bit drops without its clear input;
- that a level of 30 or more always sets the level bit.

Some behaviour only the bench scenarios can show. These are byte ordering through wrap-around, the exact threshold for each select code, that a clear is refused while the level is high, and that bytes from before a flush never reappear. The bench covers them by comparing a queue-based model against every output on every cycle.

// File: rtl/uart_wm_fifo_pkg.sv
package uart_wm_fifo_pkg;
  localparam int unsigned IRQ_LVL = 0;
  localparam int unsigned IRQ_OVF = 1;
  localparam int unsigned N_IRQ   = 2;

  // threshold chosen by the select code
  function automatic int unsigned wm_threshold(input logic [2:0] sel);
    unique case (sel)
      3'd0:    return 1;
      3'd1:    return 4;
      3'd2:    return 8;
      3'd3:    return 16;
      default: return 30;
    endcase
  endfunction
endpackage

// File: rtl/wmf_store.sv
module wmf_store #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned WIDTH = 8,
  localparam int unsigned PTRW = $clog2(DEPTH),
  localparam int unsigned LVLW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] data_o,
  output logic [LVLW-1:0]  level_o,
  output logic             full_o,
  output logic             empty_o,
  output logic             push_take_o,
  output logic             pop_take_o,
  output logic             push_drop_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTRW-1:0]  wr_ptr_q, rd_ptr_q;
  logic [LVLW-1:0]  cnt_q;

  function automatic logic [PTRW-1:0] ptr_inc(input logic [PTRW-1:0] p);
    return (p == PTRW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o      = (cnt_q == LVLW'(DEPTH));
  assign empty_o     = (cnt_q == '0);
  assign pop_take_o  = pop_i & ~empty_o & ~flush_i;
  assign push_take_o = push_i & ~flush_i & (~full_o | pop_take_o);
  assign push_drop_o = push_i & ~flush_i & full_o & ~pop_take_o;
  assign data_o      = mem_q[rd_ptr_q];
  assign level_o     = cnt_q;

  always_ff @(posedge clk_i) begin
    if (push_take_o) mem_q[wr_ptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_take_o) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop_take_o)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      unique case ({push_take_o, pop_take_o})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/wmf_irq.sv
module wmf_irq
  import uart_wm_fifo_pkg::*;
#(
  parameter int unsigned LVLW = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LVLW-1:0]   level_i,
  input  logic [2:0]        wm_sel_i,
  input  logic              ovf_evt_i,
  input  logic [N_IRQ-1:0]  clr_i,
  input  logic [N_IRQ-1:0]  en_i,
  output logic [N_IRQ-1:0]  state_o,
  output logic [N_IRQ-1:0]  irq_o
);
  logic [LVLW-1:0]  wm_lvl;
  logic [N_IRQ-1:0] set_evt;
  logic [N_IRQ-1:0] state_q;

  assign wm_lvl           = LVLW'(wm_threshold(wm_sel_i));
  assign set_evt[IRQ_LVL] = (level_i >= wm_lvl);
  assign set_evt[IRQ_OVF] = ovf_evt_i;

  // set wins over clear; the level bit re-arms while the level stays high
  for (genvar i = 0; i < N_IRQ; i++) begin : g_state
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) state_q[i] <= 1'b0;
      else         state_q[i] <= set_evt[i] | (state_q[i] & ~clr_i[i]);
    end
  end

  assign state_o = state_q;
  assign irq_o   = state_q & en_i;
endmodule

// File: rtl/uart_wm_fifo.sv
module uart_wm_fifo
  import uart_wm_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned WIDTH = 8,
  localparam int unsigned LVLW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] push_data_i,
  output logic             push_ready_o,
  input  logic             pop_i,
  output logic [WIDTH-1:0] pop_data_o,
  output logic             pop_valid_o,
  output logic [LVLW-1:0]  level_o,
  input  logic [2:0]       wm_sel_i,
  input  logic [1:0]       irq_en_i,
  input  logic [1:0]       irq_clr_i,
  output logic [1:0]       irq_state_o,
  output logic [1:0]       irq_o
);
  logic full, empty, push_take, pop_take, push_drop;

  wmf_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (flush_i),
    .push_i      (push_i),
    .data_i      (push_data_i),
    .pop_i       (pop_i),
    .data_o      (pop_data_o),
    .level_o     (level_o),
    .full_o      (full),
    .empty_o     (empty),
    .push_take_o (push_take),
    .pop_take_o  (pop_take),
    .push_drop_o (push_drop)
  );

  wmf_irq #(.LVLW(LVLW)) u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .level_i   (level_o),
    .wm_sel_i  (wm_sel_i),
    .ovf_evt_i (push_drop),
    .clr_i     (irq_clr_i),
    .en_i      (irq_en_i),
    .state_o   (irq_state_o),
    .irq_o     (irq_o)
  );

  assign push_ready_o = ~full;
  assign pop_valid_o  = ~empty;
endmodule

// File: rtl/wmf_chk.sv
module wmf_chk #(
  parameter int unsigned LVLW = 6
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            flush_i,
  input logic            push_i,
  input logic            pop_i,
  input logic            push_ready_o,
  input logic            pop_valid_o,
  input logic [LVLW-1:0] level_o,
  input logic [1:0]      irq_clr_i,
  input logic [1:0]      irq_state_o
);
  assert_level_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= LVLW'(32));

  assert_valid_level_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_valid_o == (level_o != '0));

  assert_ready_level_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_ready_o == (level_o != LVLW'(32)));

  assert_ovf_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !push_ready_o && !pop_i && !flush_i) |=> irq_state_o[1]);

  assert_full_swap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i && !push_ready_o && !flush_i) |=> (level_o == LVLW'(32)));

  assert_empty_pop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !pop_valid_o && !push_i && !flush_i) |=> (level_o == '0));

  assert_high_level_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_o >= LVLW'(30)) |=> irq_state_o[0]);

  assert_lvl_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_state_o[0] && !irq_clr_i[0]) |=> irq_state_o[0]);

  assert_ovf_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_state_o[1] && !irq_clr_i[1]) |=> irq_state_o[1]);

  assert_flush_empty_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (level_o == '0));
endmodule

bind uart_wm_fifo wmf_chk #(.LVLW(LVLW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .flush_i      (flush_i),
  .push_i       (push_i),
  .pop_i        (pop_i),
  .push_ready_o (push_ready_o),
  .pop_valid_o  (pop_valid_o),
  .level_o      (level_o),
  .irq_clr_i    (irq_clr_i),
  .irq_state_o  (irq_state_o)
);

// File: tb/uart_wm_fifo_tb_top.sv
module uart_wm_fifo_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       flush = 1'b0, push = 1'b0, pop = 1'b0;
  logic [7:0] pdata = '0;
  logic [2:0] sel = '0;
  logic [1:0] en = '0, iclr = '0;
  logic       ready, valid;
  logic [7:0] odata;
  logic [5:0] level;
  logic [1:0] st, irq;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  byte unsigned mq[$];
  bit m_lvl = 0, m_ovf = 0;
  byte unsigned seq = 8'h10;

  always #4 clk = ~clk;

  uart_wm_fifo dut_i (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush), .push_i(push),
    .push_data_i(pdata), .push_ready_o(ready), .pop_i(pop),
    .pop_data_o(odata), .pop_valid_o(valid), .level_o(level),
    .wm_sel_i(sel), .irq_en_i(en), .irq_clr_i(iclr),
    .irq_state_o(st), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  function automatic int thr(input logic [2:0] s);
    if (s == 0) return 1;
    if (s >= 4) return 30;
    return 4 << (s - 1);
  endfunction

  task automatic compare_all();
    logic [1:0] ms;
    ms = {m_ovf, m_lvl};
    chk("R2 level", level, mq.size());
    chk("R2 ready", ready, mq.size() < 32);
    chk("R2 valid", valid, mq.size() > 0);
    if (mq.size() > 0) chk("R1 head byte", odata, mq[0]);
    chk("R6/R7 level state", st[0], ms[0]);
    chk("R3/R8 overflow state", st[1], ms[1]);
    chk("R10 irq gating", irq, ms & en);
  endtask

  // one clock: model follows the same edge, outputs compared mid-cycle
  task automatic tick();
    int  n;
    bit  full, dp, dpu, ov;
    @(posedge clk);
    cyc++;
    n    = mq.size();
    full = (n == 32);
    ov   = push && full && !pop && !flush;
    m_lvl = (n >= thr(sel)) || (m_lvl && !iclr[0]);
    m_ovf = ov || (m_ovf && !iclr[1]);
    if (flush) mq.delete();
    else begin
      dp  = pop && (n > 0);
      dpu = push && (!full || dp);
      if (dp)  void'(mq.pop_front());
      if (dpu) mq.push_back(pdata);
    end
    @(negedge clk);
    compare_all();
  endtask

  task automatic drv(input bit pu, input bit po, input bit fl, input logic [1:0] cl);
    push = pu; pop = po; flush = fl; iclr = cl;
    if (pu) begin pdata = seq; seq = seq + 8'd7; end
    tick();
    push = 0; pop = 0; flush = 0; iclr = 0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : stim
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    chk("R2 reset level", level, 0);
    chk("R2 reset state", st, 0);
    rst_n = 1'b1;
    @(negedge clk);
    compare_all();

    // R6/R7: threshold 8, fill to 10, drain to 5, clear
    sel = 3'd2; en = 2'b11;
    for (int i = 0; i < 10; i++) drv(1, 0, 0, 2'b00);
    chk("R6 set at 8", st[0], 1);
    drv(0, 0, 0, 2'b01);  // level 10: clear refused
    chk("R7 clear refused while high", st[0], 1);
    for (int i = 0; i < 5; i++) drv(0, 1, 0, 2'b00);
    chk("R7 sticky below threshold", st[0], 1);
    drv(0, 0, 0, 2'b01);
    chk("R7 cleared below threshold", st[0], 0);

    // R1/R3/R4: fill to full with threshold 30, overflow, swap at full
    sel = 3'd6;
    while (level != 6'd32) drv(1, 0, 0, 2'b00);
    chk("R6 code 6 gives 30", st[0], 1);
    drv(1, 0, 0, 2'b00);
    chk("R3 push at full dropped", level, 32);
    chk("R3 overflow set", st[1], 1);
    drv(0, 0, 0, 2'b10);
    chk("R8 overflow cleared", st[1], 0);
    drv(1, 1, 0, 2'b00);
    chk("R4 swap keeps 32", level, 32);
    chk("R4 no overflow", st[1], 0);
    drv(1, 0, 0, 2'b00);
    drv(1, 0, 0, 2'b10);
    chk("R8 set wins over clear", st[1], 1);
    en = 2'b01;
    drv(0, 0, 0, 2'b00);
    chk("R10 overflow masked", irq[1], 0);
    en = 2'b11;

    // R1 drain through wrap, R5 pop when empty
    while (level != 0) drv(0, 1, 0, 2'b00);
    drv(0, 1, 0, 2'b00);
    chk("R5 pop on empty", level, 0);
    drv(1, 1, 0, 2'b00);
    chk("R5 pop+push on empty", level, 1);

    // R9 flush at full with push and pop
    drv(0, 0, 0, 2'b11);
    while (level != 6'd32) drv(1, 0, 0, 2'b00);
    drv(1, 1, 1, 2'b00);
    chk("R9 flush empties", level, 0);
    drv(1, 0, 0, 2'b00);
    chk("R9 fresh byte after flush", odata, mq[0]);
    drv(0, 1, 0, 2'b00);

    // R6: every select code
    for (int s = 0; s < 8; s++) begin
      sel = 3'(s);
      drv(0, 0, 1, 2'b00);
      drv(0, 0, 0, 2'b11);
      drv(0, 0, 0, 2'b11);
      chk("R6 clear before code", st[0], 0);
      for (int k = 0; k < thr(3'(s)) - 1; k++) drv(1, 0, 0, 2'b00);
      drv(0, 0, 0, 2'b00);
      chk("R6 below threshold", st[0], 0);
      drv(1, 0, 0, 2'b00);
      drv(0, 0, 0, 2'b00);
      chk("R6 at threshold", st[0], 1);
    end

    // mixed traffic
    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      sel = lfsr[10:8];
      en  = lfsr[12:11];
      drv(lfsr[0] | lfsr[1], lfsr[2] & lfsr[3], lfsr[15:4] == 12'h0A5 || (i % 700) == 699,
          {lfsr[5] & lfsr[6], lfsr[7] & lfsr[14]});
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule